// File: doc/BRIEF.md
# SDRAM Command Bus Monitor with Bank Tracking

This block watches the command pins of a four-bank SDRAM interface on every rising clock edge without driving anything back. It turns the pin levels of each edge into one decoded command, follows the open or closed state of every bank together with the row that was opened, and counts clocks between related commands so that sequences breaking the command protocol or the minimum clock spacings are caught.

Each rule has its own bit in a violation vector. A bit stays set until reset. A separate error code records which rule broke first. The monitor sits beside a memory controller in simulation or in silicon, so protocol faults show up at the edge where they happen and not as corrupted data much later. Electrical behaviour, data contents and the low-power modes are not examined.

All outputs are registered. After an edge they show the result of the pins sampled at that edge. Spacing rules are written as a number of clock edges between two commands: a command at edge e and a later one at edge e+N are N clocks apart. Every edge counts, including skipped and deselected ones. Default spacings are RCD=3, RAS=6, RP=3, RRD=2, MRD=2 and write recovery WR=2 clocks.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: When the edge is decoded with chip select low, the command code is set by {ras_n,cas_n,we_n} and addr[10]: 111 gives NOP=2, 110 gives BST=3, 101 gives READ=4 (addr[10]=0) or READ_AP=5 (addr[10]=1), 100 gives WRITE=6 or WRITE_AP=7, 011 gives ACT=8, 010 gives PRE=9 (addr[10]=0) or PALL=10 (addr[10]=1), 001 gives REF=11 and 000 gives MRS=12.
- R2: An edge is skipped when cke was low at the previous edge. A skipped edge reports code 0 and changes no bank state. The first edge after reset is always skipped.
- R3: With cs_n high the edge reports DESL=1, every other pin is ignored, and the banks keep their state and rows.
- R4: ACT sets bank_open[ba] and stores addr in row slice ba of bank_row, replacing any row already held there. PRE closes only bank ba. PALL closes every open bank.
- R5: A READ or WRITE of either kind sets violation bit 0 if its bank is idle. If the bank is open but fewer than RCD clocks have passed since that bank's ACT, it sets bit 2.
- R6: ACT to a bank that is already open sets bit 1. ACT fewer than RRD clocks after an ACT to a different bank sets bit 3.
- R7: PRE or PALL that closes a bank fewer than RAS clocks after that bank's ACT sets bit 4. ACT to an idle bank fewer than RP clocks after that bank was closed sets bit 5. PRE to a bank that is already idle does not restart its RP window.
- R8: MRS loads the burst length from addr[2:0]: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and any other value gives 1. Length 1 also applies after reset. MRS with any bank open sets bit 6. ACT fewer than MRD clocks after MRS sets bit 7.
- R9: REF with any bank open sets bit 8. REF with all banks idle changes nothing.
- R10: READ_AP to an open bank closes that bank at the edge BL clocks later. WRITE_AP closes it at the edge BL+WR clocks later. That closing edge starts the bank's RP window.
- R11: Violation bits are sticky until reset. err_o is 0 until the first edge with any violation. At that edge it takes 1 + the lowest violation bit index set there, and it then holds that value until reset.
- R12: During reset cmd_o, bank_open, viol_o and err_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Address pins; bit 10 selects the auto-precharge or all-bank variant |
| cmd_o | output | 4 | Code of the command decoded at the last edge |
| bank_open | output | 4 | One bit per bank, set while the bank is open |
| bank_row | output | 52 | Open row per bank, 13 bits each, bank 0 in the low bits |
| viol_o | output | 9 | Sticky violation vector |
| err_o | output | 4 | Code of the first violation |

## Verification
The hardest case to reach from the pins is an auto-precharge close that lands on the same edge as another command or inside a spacing window. Only a column command with addr[10] high, issued a set number of clocks after a mode set that chose the burst length, gets there. The bench builds these sequences on purpose for both read and write. It then runs many short bursts of random pin patterns, with reset between them, so that close edges collide with ACT, PRE, REF and MRS. A behavioural model built on edge indices is compared with every output on every clock.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_SKIP  = 4'd0,
    CMD_DESL  = 4'd1,
    CMD_NOP   = 4'd2,
    CMD_BST   = 4'd3,
    CMD_RD    = 4'd4,
    CMD_RDA   = 4'd5,
    CMD_WR    = 4'd6,
    CMD_WRA   = 4'd7,
    CMD_ACT   = 4'd8,
    CMD_PRE   = 4'd9,
    CMD_PALL  = 4'd10,
    CMD_REF   = 4'd11,
    CMD_MRS   = 4'd12
  } cmd_e;

  localparam int NUM_VIOL   = 9;
  localparam int ERR_W      = $clog2(NUM_VIOL + 1);
  localparam int MAX_BURST  = 8;
  localparam int BLEN_W     = $clog2(MAX_BURST + 1);

  localparam int V_COL_IDLE = 0;
  localparam int V_ACT_OPEN = 1;
  localparam int V_RCD      = 2;
  localparam int V_RRD      = 3;
  localparam int V_RAS      = 4;
  localparam int V_RP       = 5;
  localparam int V_MRS_BUSY = 6;
  localparam int V_MRD      = 7;
  localparam int V_REF_BUSY = 8;

  function automatic logic [BLEN_W-1:0] burst_of(input logic [2:0] code);
    case (code)
      3'd1:    return BLEN_W'(2);
      3'd2:    return BLEN_W'(4);
      3'd3:    return BLEN_W'(8);
      default: return BLEN_W'(1);
    endcase
  endfunction

  function automatic logic is_column(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke_prev,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd
);

  always_comb begin
    if (!cke_prev) begin
      cmd = CMD_SKIP;
    end else if (cs_n) begin
      cmd = CMD_DESL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b110:  cmd = CMD_BST;
        3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
        3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = a10 ? CMD_PALL : CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot
  import sdram_mon_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int CNT_LIM = 16,
  parameter int RCD_CLK = 3,
  parameter int RAS_CLK = 6,
  parameter int RP_CLK  = 3,
  parameter int WR_CLK  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic              hit,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [BLEN_W-1:0] burst_len,
  output logic              is_open,
  output logic [ROW_W-1:0]  open_row,
  output logic              v_col_idle,
  output logic              v_act_open,
  output logic              v_rcd,
  output logic              v_ras,
  output logic              v_rp
);

  localparam int CNT_W = $clog2(CNT_LIM + 1);
  localparam int AP_W  = $clog2(MAX_BURST + WR_CLK + 1);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(CNT_LIM);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic              open_q, open_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [CNT_W-1:0]  act_cnt_q, act_cnt_d;
  logic [CNT_W-1:0]  pre_cnt_q, pre_cnt_d;
  logic [AP_W-1:0]   ap_q, ap_d;
  logic              col_hit, close_req, act_hit;

  assign col_hit   = hit && is_column(cmd);
  assign act_hit   = hit && (cmd == CMD_ACT);
  assign close_req = (hit && (cmd == CMD_PRE)) || (cmd == CMD_PALL);

  assign v_col_idle = col_hit && !open_q;
  assign v_rcd      = col_hit && open_q && (act_cnt_q < CNT_W'(RCD_CLK));
  assign v_act_open = act_hit && open_q;
  assign v_rp       = act_hit && !open_q && (pre_cnt_q < CNT_W'(RP_CLK));
  assign v_ras      = close_req && open_q && (act_cnt_q < CNT_W'(RAS_CLK));

  always_comb begin
    open_d    = open_q;
    row_d     = row_q;
    ap_d      = ap_q;
    act_cnt_d = (act_cnt_q == LIM_V) ? act_cnt_q : act_cnt_q + ONE_V;
    pre_cnt_d = (pre_cnt_q == LIM_V) ? pre_cnt_q : pre_cnt_q + ONE_V;

    // auto-precharge countdown, ends at the edge it reaches one
    if (ap_q != '0) begin
      ap_d = ap_q - AP_W'(1);
      if (ap_q == AP_W'(1)) begin
        open_d    = 1'b0;
        pre_cnt_d = ONE_V;
      end
    end

    if (act_hit) begin
      open_d    = 1'b1;
      row_d     = row_in;
      act_cnt_d = ONE_V;
      ap_d      = '0;
    end else if (close_req && open_q) begin
      open_d    = 1'b0;
      pre_cnt_d = ONE_V;
      ap_d      = '0;
    end else if (col_hit && open_q && (cmd == CMD_RDA)) begin
      ap_d = AP_W'(burst_len);
    end else if (col_hit && open_q && (cmd == CMD_WRA)) begin
      ap_d = AP_W'(burst_len) + AP_W'(WR_CLK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      row_q     <= '0;
      ap_q      <= '0;
      act_cnt_q <= LIM_V;
      pre_cnt_q <= LIM_V;
    end else begin
      open_q    <= open_d;
      row_q     <= row_d;
      ap_q      <= ap_d;
      act_cnt_q <= act_cnt_d;
      pre_cnt_q <= pre_cnt_d;
    end
  end

  assign is_open  = open_q;
  assign open_row = row_q;

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int ROW_W   = 13,
  parameter int AP_BIT  = 10,
  parameter int RCD_CLK = 3,
  parameter int RAS_CLK = 6,
  parameter int RP_CLK  = 3,
  parameter int RRD_CLK = 2,
  parameter int MRD_CLK = 2,
  parameter int WR_CLK  = 2,
  localparam int BA_W   = $clog2(BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic [ROW_W-1:0]       addr,
  output logic [3:0]             cmd_o,
  output logic [BANKS-1:0]       bank_open,
  output logic [BANKS*ROW_W-1:0] bank_row,
  output logic [NUM_VIOL-1:0]    viol_o,
  output logic [ERR_W-1:0]       err_o
);

  localparam int CNT_LIM = RCD_CLK + RAS_CLK + RP_CLK + RRD_CLK + MRD_CLK;
  localparam int CNT_W   = $clog2(CNT_LIM + 1);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(CNT_LIM);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic                  cke_q;
  cmd_e                  cmd_now, cmd_q;
  logic [BLEN_W-1:0]     bl_q, bl_d;
  logic [CNT_W-1:0]      any_cnt_q, any_cnt_d;
  logic [CNT_W-1:0]      mrs_cnt_q, mrs_cnt_d;
  logic [BA_W-1:0]       last_ba_q, last_ba_d;
  logic [NUM_VIOL-1:0]   viol_q, viol_now;
  logic [ERR_W-1:0]      err_q, err_d, first_code;
  logic                  is_act;

  logic [BANKS-1:0]      vb_col_idle, vb_act_open, vb_rcd, vb_ras, vb_rp;
  logic [ROW_W-1:0]      b_row [BANKS];

  sdram_cmd_decode u_dec (
    .cke_prev (cke_q),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (addr[AP_BIT]),
    .cmd      (cmd_now)
  );

  for (genvar gi = 0; gi < BANKS; gi++) begin : g_bank
    sdram_bank_slot #(
      .ROW_W   (ROW_W),
      .CNT_LIM (CNT_LIM),
      .RCD_CLK (RCD_CLK),
      .RAS_CLK (RAS_CLK),
      .RP_CLK  (RP_CLK),
      .WR_CLK  (WR_CLK)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd_now),
      .hit        (ba == BA_W'(gi)),
      .row_in     (addr),
      .burst_len  (bl_q),
      .is_open    (bank_open[gi]),
      .open_row   (b_row[gi]),
      .v_col_idle (vb_col_idle[gi]),
      .v_act_open (vb_act_open[gi]),
      .v_rcd      (vb_rcd[gi]),
      .v_ras      (vb_ras[gi]),
      .v_rp       (vb_rp[gi])
    );
    assign bank_row[gi*ROW_W +: ROW_W] = b_row[gi];
  end

  assign is_act = (cmd_now == CMD_ACT);

  always_comb begin
    viol_now             = '0;
    viol_now[V_COL_IDLE] = |vb_col_idle;
    viol_now[V_ACT_OPEN] = |vb_act_open;
    viol_now[V_RCD]      = |vb_rcd;
    viol_now[V_RRD]      = is_act && (any_cnt_q < CNT_W'(RRD_CLK)) && (ba != last_ba_q);
    viol_now[V_RAS]      = |vb_ras;
    viol_now[V_RP]       = |vb_rp;
    viol_now[V_MRS_BUSY] = (cmd_now == CMD_MRS) && (|bank_open);
    viol_now[V_MRD]      = is_act && (mrs_cnt_q < CNT_W'(MRD_CLK));
    viol_now[V_REF_BUSY] = (cmd_now == CMD_REF) && (|bank_open);
  end

  // lowest set index wins
  always_comb begin
    first_code = '0;
    for (int i = NUM_VIOL - 1; i >= 0; i--) begin
      if (viol_now[i]) first_code = ERR_W'(i + 1);
    end
  end

  always_comb begin
    any_cnt_d = (any_cnt_q == LIM_V) ? any_cnt_q : any_cnt_q + ONE_V;
    mrs_cnt_d = (mrs_cnt_q == LIM_V) ? mrs_cnt_q : mrs_cnt_q + ONE_V;
    last_ba_d = last_ba_q;
    bl_d      = bl_q;
    if (is_act) begin
      any_cnt_d = ONE_V;
      last_ba_d = ba;
    end
    if (cmd_now == CMD_MRS) begin
      mrs_cnt_d = ONE_V;
      bl_d      = burst_of(addr[2:0]);
    end
    err_d = ((err_q == '0) && (|viol_now)) ? first_code : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b0;
      cmd_q     <= CMD_SKIP;
      bl_q      <= BLEN_W'(1);
      any_cnt_q <= LIM_V;
      mrs_cnt_q <= LIM_V;
      last_ba_q <= '0;
      viol_q    <= '0;
      err_q     <= '0;
    end else begin
      cke_q     <= cke;
      cmd_q     <= cmd_now;
      bl_q      <= bl_d;
      any_cnt_q <= any_cnt_d;
      mrs_cnt_q <= mrs_cnt_d;
      last_ba_q <= last_ba_d;
      viol_q    <= viol_q | viol_now;
      err_q     <= err_d;
    end
  end

  assign cmd_o  = cmd_q;
  assign viol_o = viol_q;
  assign err_o  = err_q;

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int BANKS    = 4,
  parameter int BA_W     = 2,
  parameter int ROW_W    = 13,
  parameter int NUM_VIOL = 9,
  parameter int ERR_W    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cke_q,
  input logic                   cs_n,
  input logic                   ras_n,
  input logic                   cas_n,
  input logic                   we_n,
  input logic                   a10,
  input logic [BA_W-1:0]        ba,
  input logic [3:0]             cmd_o,
  input logic [BANKS-1:0]       bank_open,
  input logic [BANKS*ROW_W-1:0] bank_row,
  input logic [NUM_VIOL-1:0]    viol_o,
  input logic [ERR_W-1:0]       err_o
);

  logic sel_in, act_in, pall_in, ref_in;
  assign sel_in  = cke_q && !cs_n;
  assign act_in  = sel_in && !ras_n && cas_n && we_n;
  assign pall_in = sel_in && !ras_n && cas_n && !we_n && a10;
  assign ref_in  = sel_in && !ras_n && !cas_n && we_n;

  // R2
  skip_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> (cmd_o == 4'd0));

  // R3
  desl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && cs_n) |=> ((cmd_o == 4'd1) && $stable(bank_row)));

  // R4
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_in |=> bank_open[$past(ba)]);

  // R4
  pall_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pall_in |=> (bank_open == '0));

  // R9
  ref_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_in && (|bank_open)) |=> viol_o[8]);

  // R11
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((viol_o & $past(viol_o)) == $past(viol_o)));

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_o) != '0) |-> (err_o == $past(err_o)));

  // R11
  err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_o != '0) == (viol_o != '0)));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
  .BANKS    (BANKS),
  .BA_W     (BA_W),
  .ROW_W    (ROW_W),
  .NUM_VIOL (sdram_mon_pkg::NUM_VIOL),
  .ERR_W    (sdram_mon_pkg::ERR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke_q     (cke_q),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .a10       (addr[AP_BIT]),
  .ba        (ba),
  .cmd_o     (cmd_o),
  .bank_open (bank_open),
  .bank_row  (bank_row),
  .viol_o    (viol_o),
  .err_o     (err_o)
);

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RCD = 3, RAS = 6, RP = 3, RRD = 2, MRD = 2, WRC = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  cmd_o;
  logic [3:0]  bank_open;
  logic [51:0] bank_row;
  logic [8:0]  viol_o;
  logic [3:0]  err_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
    .bank_open(bank_open), .bank_row(bank_row), .viol_o(viol_o), .err_o(err_o)
  );

  // ---------------- reference model (edge-index based) ----------------
  int m_open[4], m_row[4], m_tact[4], m_tpre[4], m_apend[4];
  int m_cyc, m_tany, m_lastba, m_tmrs, m_bl, m_ckep, m_cmd, m_viol, m_err;

  function automatic int dec(int ckep, logic cs, logic r, logic c, logic w, logic a10);
    if (ckep == 0) return 0;
    if (cs) return 1;
    case ({r, c, w})
      3'b111: return 2;
      3'b110: return 3;
      3'b101: return a10 ? 5 : 4;
      3'b100: return a10 ? 7 : 6;
      3'b011: return 8;
      3'b010: return a10 ? 10 : 9;
      3'b001: return 11;
      default: return 12;
    endcase
  endfunction

  function automatic int blen(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_open[i] = 0; m_row[i] = 0; m_tact[i] = -100; m_tpre[i] = -100; m_apend[i] = -1;
      end
      m_cyc = 0; m_tany = -100; m_lastba = 0; m_tmrs = -100; m_bl = 1;
      m_ckep = 0; m_cmd = 0; m_viol = 0; m_err = 0;
    end else begin
      int c, v, b, anyopen;
      int popen[4];
      m_cyc++;
      c = dec(m_ckep, cs_n, ras_n, cas_n, we_n, addr[10]);
      b = ba;
      v = 0;
      anyopen = 0;
      for (int i = 0; i < 4; i++) begin
        popen[i] = m_open[i];
        if (m_open[i] != 0) anyopen = 1;
      end
      if (c >= 4 && c <= 7) begin
        if (popen[b] == 0) v |= 1;
        else if (m_cyc - m_tact[b] < RCD) v |= 4;
      end
      if (c == 8) begin
        if (popen[b] != 0) v |= 2;
        else if (m_cyc - m_tpre[b] < RP) v |= 32;
        if ((m_cyc - m_tany < RRD) && (b != m_lastba)) v |= 8;
        if (m_cyc - m_tmrs < MRD) v |= 128;
      end
      if (c == 9 && popen[b] != 0 && (m_cyc - m_tact[b] < RAS)) v |= 16;
      if (c == 10)
        for (int i = 0; i < 4; i++)
          if (popen[i] != 0 && (m_cyc - m_tact[i] < RAS)) v |= 16;
      if (c == 12 && anyopen != 0) v |= 64;
      if (c == 11 && anyopen != 0) v |= 256;
      for (int i = 0; i < 4; i++)
        if (m_apend[i] == m_cyc) begin
          m_open[i] = 0; m_tpre[i] = m_cyc; m_apend[i] = -1;
        end
      if (c == 8) begin
        m_open[b] = 1; m_row[b] = addr; m_tact[b] = m_cyc; m_apend[b] = -1;
        m_tany = m_cyc; m_lastba = b;
      end
      if (c == 9 && popen[b] != 0) begin
        m_open[b] = 0; m_tpre[b] = m_cyc; m_apend[b] = -1;
      end
      if (c == 10)
        for (int i = 0; i < 4; i++)
          if (popen[i] != 0) begin
            m_open[i] = 0; m_tpre[i] = m_cyc; m_apend[i] = -1;
          end
      if ((c == 5 || c == 7) && popen[b] != 0)
        m_apend[b] = m_cyc + m_bl + ((c == 7) ? WRC : 0);
      if (c == 12) begin
        m_bl = blen(int'(addr[2:0])); m_tmrs = m_cyc;
      end
      m_cmd = c;
      if (m_err == 0 && v != 0)
        for (int i = 8; i >= 0; i--) if (v[i]) m_err = i + 1;
      m_viol |= v;
      m_ckep = cke;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    int ov;
    ov = 0;
    for (int i = 0; i < 4; i++) if (m_open[i] != 0) ov |= (1 << i);
    chk("R1 command code", int'(cmd_o), m_cmd);
    chk("R4 bank open vector", int'(bank_open), ov);
    for (int i = 0; i < 4; i++)
      if (m_open[i] != 0) chk("R4 open row", int'(bank_row[i*13 +: 13]), m_row[i]);
    chk("R11 violation vector", int'(viol_o), m_viol);
    chk("R11 error code", int'(err_o), m_err);
  endtask

  task automatic drive(input logic k, input logic cs, input logic r, input logic c,
                       input logic w, input logic [1:0] b, input logic [12:0] a);
    cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic nop();                      drive(1, 0, 1, 1, 1, 0, 0);            endtask
  task automatic idle(input int n);          for (int i = 0; i < n; i++) nop();       endtask
  task automatic act(input int b, input int row); drive(1, 0, 0, 1, 1, 2'(b), 13'(row)); endtask
  task automatic rd(input int b, input int ap);   drive(1, 0, 1, 0, 1, 2'(b), 13'(ap << 10)); endtask
  task automatic wr(input int b, input int ap);   drive(1, 0, 1, 0, 0, 2'(b), 13'(ap << 10)); endtask
  task automatic pre(input int b);           drive(1, 0, 0, 1, 0, 2'(b), 13'h0000);  endtask
  task automatic pall();                     drive(1, 0, 0, 1, 0, 2'd0, 13'h0400);   endtask
  task automatic refr();                     drive(1, 0, 0, 0, 1, 2'd0, 13'h0000);   endtask
  task automatic mrs(input int code);        drive(1, 0, 0, 0, 0, 2'd0, 13'(code));  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cke = 1; cs_n = 0; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;
    @(negedge clk);
    @(negedge clk);
    // R12 reset values
    chk("R12 reset cmd", int'(cmd_o), 0);
    chk("R12 reset open", int'(bank_open), 0);
    chk("R12 reset viol", int'(viol_o), 0);
    chk("R12 reset err", int'(err_o), 0);
    rst_n = 1'b1;
    act(1, 77);  // first edge after reset is skipped
    chk("R2 first edge skipped code", int'(cmd_o), 0);
    chk("R2 first edge no open", int'(bank_open[1]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cke = 1; cs_n = 0; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;

    // R1 / R3: every command code
    do_reset();
    mrs(0);   chk("R1 MRS", int'(cmd_o), 12);
    nop();    chk("R1 NOP", int'(cmd_o), 2);
    drive(1, 1, 0, 1, 1, 2'd2, 13'd5);
    chk("R3 deselect code", int'(cmd_o), 1);
    chk("R3 deselect ignores ACT pattern", int'(bank_open[2]), 0);
    drive(1, 0, 1, 1, 0, 0, 0); chk("R1 BST", int'(cmd_o), 3);
    refr();   chk("R1 REF", int'(cmd_o), 11);
    act(0, 5); chk("R1 ACT", int'(cmd_o), 8);
    rd(0, 0); chk("R1 READ", int'(cmd_o), 4);
    rd(0, 1); chk("R1 READ_AP", int'(cmd_o), 5);
    wr(0, 0); chk("R1 WRITE", int'(cmd_o), 6);
    wr(0, 1); chk("R1 WRITE_AP", int'(cmd_o), 7);
    pre(0);   chk("R1 PRE", int'(cmd_o), 9);
    pall();   chk("R1 PALL", int'(cmd_o), 10);

    // R2: edge after cke low is skipped
    do_reset();
    nop();
    drive(0, 0, 1, 1, 1, 0, 0);
    act(1, 9);
    chk("R2 skipped code", int'(cmd_o), 0);
    chk("R2 skipped ACT no open", int'(bank_open[1]), 0);
    act(1, 9);
    chk("R2 resumed ACT", int'(bank_open[1]), 1);

    // R4: legal flow, rows, selective PRE, PALL
    do_reset();
    nop();
    act(2, 13'h1234);
    chk("R4 row stored", int'(bank_row[26 +: 13]), 13'h1234);
    idle(2);
    rd(2, 0);
    idle(2);
    pre(2);
    chk("R4 PRE closes", int'(bank_open[2]), 0);
    chk("R4 legal flow no violation", int'(viol_o), 0);
    act(0, 1); nop(); act(3, 2);
    idle(6);
    pre(0);
    chk("R4 PRE selected only", int'(bank_open), 4'b1000);
    act(1, 3); idle(6);
    pall();
    chk("R4 PALL closes all", int'(bank_open), 0);
    chk("R4 spacings legal", int'(viol_o), 0);

    // R5: RCD then idle-bank column; R11 first code held
    do_reset();
    nop();
    act(1, 7);
    rd(1, 0);
    chk("R5 RCD bit", int'(viol_o[2]), 1);
    chk("R11 first code RCD", int'(err_o), 3);
    wr(3, 0);
    chk("R5 idle column bit", int'(viol_o[0]), 1);
    chk("R11 code held", int'(err_o), 3);

    // R6: RRD across banks and ACT to open bank
    do_reset();
    nop();
    act(0, 1);
    act(3, 2);
    chk("R6 RRD bit", int'(viol_o), 9'h008);
    nop();
    act(0, 9);
    chk("R6 ACT to open bit", int'(viol_o[1]), 1);
    chk("R11 first code RRD", int'(err_o), 4);

    // R7: RAS and RP
    do_reset();
    nop();
    act(2, 3); idle(2);
    pre(2);
    chk("R7 RAS bit", int'(viol_o), 9'h010);
    act(2, 3);
    chk("R7 RP bit", int'(viol_o[5]), 1);
    do_reset();
    nop();
    act(1, 4); idle(5);
    pre(1); idle(2);
    pre(1);   // bank already idle
    act(1, 4);
    chk("R7 PRE on idle bank keeps window", int'(viol_o), 0);

    // R8: MRS with open bank, MRD
    do_reset();
    nop();
    act(0, 1);
    mrs(2);
    chk("R8 MRS busy bit", int'(viol_o[6]), 1);
    do_reset();
    mrs(3);
    act(1, 4);
    chk("R8 MRD bit", int'(viol_o), 9'h080);

    // R9: REF
    do_reset();
    refr();
    chk("R9 REF idle legal", int'(viol_o), 0);
    act(3, 6);
    refr();
    chk("R9 REF busy bit", int'(viol_o[8]), 1);

    // R10: auto-precharge with burst length 4
    do_reset();
    mrs(2); nop();
    act(1, 13'h55); idle(2);
    rd(1, 1);
    chk("R10 open after READ_AP", int'(bank_open[1]), 1);
    idle(3);
    chk("R10 open before burst end", int'(bank_open[1]), 1);
    nop();
    chk("R10 READ_AP closed after BL", int'(bank_open[1]), 0);
    idle(2);
    act(1, 13'h66); idle(2);
    wr(1, 1);
    idle(5);
    chk("R10 open before write recovery end", int'(bank_open[1]), 1);
    nop();
    chk("R10 WRITE_AP closed after BL+WR", int'(bank_open[1]), 0);
    chk("R10 sequence legal", int'(viol_o), 0);

    // random bursts, model compared each clock
    for (int blk = 0; blk < 40; blk++) begin
      do_reset();
      for (int k = 0; k < 50; k++) begin
        logic [2:0] rcw;
        rcw = 3'($urandom % 8);
        if ($urandom % 3 == 0) rcw = 3'b111;
        drive(($urandom % 10) != 0, ($urandom % 8) == 0, rcw[2], rcw[1], rcw[0],
              2'($urandom % 4), 13'($urandom));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule